// File: doc/BRIEF.md
# Configurable 16-bit Pseudo-Random Sequence Generator

This block produces a 16-bit maximal-length pseudo-random state sequence and a serial bit stream taken from the rightmost stage. Two build-time parameters choose its shape. The first picks one of two structures. In the external-combining structure, selected stages are reduced to one feedback bit that enters at the left end. In the internal-combining structure, the bit leaving the right end toggles a set of stages as the register shifts. The second parameter picks plain XOR or inverted (XNOR) feedback. The tap set comes from a primitive polynomial parameter. The internal-combining structure uses the mirror image of that tap set, so both structures emit the same bit stream, shifted in time.

Software or a neighbouring block may load a seed at any time. If the seed equals the one state that locks the register for the chosen polarity, the guard stores a safe default state in its place and pulses a flag. With XNOR feedback the reset state is all zeros, which is a legal running state in that polarity.

Top module: `prbs16_core`

## Requirements
- R1: While `rst` is high, the state becomes 0xACE1 with XOR feedback and 0x0000 with XNOR feedback, and `lockup_o` is 0. Both apply from the first clock edge after reset.
- R2: With `load_en` and `step_en` both low, the state keeps its value.
- R3: External-combining step, state[15] leftmost and state[0] rightmost: next = {p, state[15:1]}, where p is the parity of (state AND 0x002D), i.e. taps at bit indices 0, 2, 3 and 5. With XNOR feedback, p is inverted.
- R4: Internal-combining step: with XOR feedback, next = (state >> 1) XOR (state[0] ? 0xB400 : 0). With XNOR feedback, next = {1, state[15:1]} XOR (state[0] ? 0 : 0xB400). The mask 0xB400 is the bit mirror of 0x002D.
- R5: `serial_o` always equals state[0].
- R6: A load of a legal seed puts that seed into the state on the next edge. A load wins over a step in the same cycle.
- R7: A load of the locking state (0x0000 for XOR, 0xFFFF for XNOR) stores 0xACE1 instead. `lockup_o` is high in the cycle after that load and low in every cycle not preceded by such a load.
- R8: From any legal state, stepping returns to that state after exactly 65535 steps and never reaches the locking state.
- R9: The XOR-feedback external and internal structures started from the same seed produce serial streams that match after some fixed offset.
- R10: An XNOR instance loaded with the complement of a seed holds the bitwise complement of the state of the XOR instance of the same structure loaded with that seed, on every step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| step_en | input | 1 | Advance the sequence by one step |
| load_en | input | 1 | Load `seed_i`; has priority over `step_en` |
| seed_i | input | 16 | Seed value |
| state_o | output | 16 | Current register state |
| serial_o | output | 1 | Rightmost state bit |
| lockup_o | output | 1 | One-cycle pulse after a refused seed |

## Verification
A seed load and a step can fall in the same cycle, and the load can carry the locking pattern while the register is running. The bench raises `load_en` with `step_en` held high, using both legal seeds and the locking pattern of each polarity. The behavioural model takes the load branch before the step branch. Each cycle, state, serial bit and flag of every variant are compared against that model. The replaced value and a flag lasting exactly one cycle are checked explicitly.

// File: rtl/prbs16_pkg.sv
package prbs16_pkg;

    localparam int STATE_W = 16;

    typedef logic [STATE_W-1:0] state_t;

    typedef enum logic {ARCH_EXT = 1'b0, ARCH_INT = 1'b1} arch_e;
    typedef enum logic {FB_XOR = 1'b0, FB_XNOR = 1'b1} fbpol_e;

    typedef struct packed {
        state_t value;
        logic   refused;
    } seed_res_t;

    function automatic state_t mirror_bits(state_t v);
        state_t r;
        for (int i = 0; i < STATE_W; i++) r[i] = v[STATE_W-1-i];
        return r;
    endfunction

    function automatic state_t lock_state(fbpol_e pol);
        return (pol == FB_XNOR) ? '1 : '0;
    endfunction

    function automatic state_t reset_state(fbpol_e pol, state_t safe);
        return (pol == FB_XNOR) ? '0 : safe;
    endfunction

endpackage

// File: rtl/prbs16_step.sv
module prbs16_step
    import prbs16_pkg::*;
#(
    parameter arch_e  ARCH = ARCH_EXT,
    parameter fbpol_e POL  = FB_XOR,
    parameter state_t POLY = 16'h002D
) (
    input  state_t cur,
    output state_t nxt
);
    localparam state_t INT_MASK = mirror_bits(POLY);

    generate
        if (ARCH == ARCH_EXT) begin : g_ext
            logic par;
            assign par = ^(cur & POLY);
            if (POL == FB_XNOR) begin : g_inv
                assign nxt = {~par, cur[STATE_W-1:1]};
            end else begin : g_pl
                assign nxt = {par, cur[STATE_W-1:1]};
            end
        end else begin : g_int
            if (POL == FB_XNOR) begin : g_inv
                assign nxt = {1'b1, cur[STATE_W-1:1]} ^ (cur[0] ? '0 : INT_MASK);
            end else begin : g_pl
                assign nxt = {1'b0, cur[STATE_W-1:1]} ^ (cur[0] ? INT_MASK : '0);
            end
        end
    endgenerate
endmodule

// File: rtl/prbs16_seed_guard.sv
module prbs16_seed_guard
    import prbs16_pkg::*;
#(
    parameter fbpol_e POL       = FB_XOR,
    parameter state_t SAFE_SEED = 16'hACE1
) (
    input  state_t    seed,
    output seed_res_t res
);
    localparam state_t BAD = lock_state(POL);

    always_comb begin
        res.refused = (seed == BAD);
        res.value   = res.refused ? SAFE_SEED : seed;
    end
endmodule

// File: rtl/prbs16_core.sv
module prbs16_core
    import prbs16_pkg::*;
#(
    parameter arch_e  ARCH      = ARCH_EXT,
    parameter fbpol_e POL       = FB_XOR,
    parameter state_t POLY      = 16'h002D,
    parameter state_t SAFE_SEED = 16'hACE1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               step_en,
    input  logic               load_en,
    input  logic [STATE_W-1:0] seed_i,
    output logic [STATE_W-1:0] state_o,
    output logic               serial_o,
    output logic               lockup_o
);
    localparam state_t RST_VAL = reset_state(POL, SAFE_SEED);

    state_t    state_q;
    state_t    nxt;
    seed_res_t guarded;
    logic      flag_q;

    prbs16_step #(.ARCH(ARCH), .POL(POL), .POLY(POLY)) u_step (
        .cur(state_q),
        .nxt(nxt)
    );

    prbs16_seed_guard #(.POL(POL), .SAFE_SEED(SAFE_SEED)) u_guard (
        .seed(seed_i),
        .res (guarded)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RST_VAL;
            flag_q  <= 1'b0;
        end else begin
            flag_q <= 1'b0;
            if (load_en) begin
                state_q <= guarded.value;
                flag_q  <= guarded.refused;
            end else if (step_en) begin
                state_q <= nxt;
            end
        end
    end

    assign state_o  = state_q;
    assign serial_o = state_q[0];
    assign lockup_o = flag_q;
endmodule

// File: rtl/prbs16_core_chk.sv
module prbs16_core_chk
    import prbs16_pkg::*;
#(
    parameter arch_e  ARCH      = ARCH_EXT,
    parameter fbpol_e POL       = FB_XOR,
    parameter state_t SAFE_SEED = 16'hACE1
) (
    input logic   clk,
    input logic   rst,
    input logic   step_en,
    input logic   load_en,
    input state_t seed_i,
    input state_t state_o,
    input logic   lockup_o
);
    localparam state_t BAD     = lock_state(POL);
    localparam state_t RST_VAL = reset_state(POL, SAFE_SEED);

    a_r1_reset: assert property (@(posedge clk)
        rst |=> (state_o == RST_VAL && !lockup_o));

    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        (!load_en && !step_en) |=> $stable(state_o));

    a_r6_load: assert property (@(posedge clk) disable iff (rst)
        (load_en && seed_i != BAD) |=> (state_o == $past(seed_i)));

    a_r7_swap: assert property (@(posedge clk) disable iff (rst)
        (load_en && seed_i == BAD) |=> (state_o == SAFE_SEED && lockup_o));

    a_r7_quiet: assert property (@(posedge clk) disable iff (rst)
        !(load_en && seed_i == BAD) |=> !lockup_o);

    a_r8_legal: assert property (@(posedge clk) disable iff (rst)
        state_o != BAD);

    generate
        if (ARCH == ARCH_EXT) begin : g_ext
            a_r3_shift: assert property (@(posedge clk) disable iff (rst)
                (step_en && !load_en) |=> (state_o[STATE_W-2:0] == $past(state_o[STATE_W-1:1])));
        end else begin : g_int
            a_r4_wrap: assert property (@(posedge clk) disable iff (rst)
                (step_en && !load_en) |=> (state_o[STATE_W-1] == $past(state_o[0])));
        end
    endgenerate
endmodule

bind prbs16_core prbs16_core_chk #(.ARCH(ARCH), .POL(POL), .SAFE_SEED(SAFE_SEED)) chk_i (
    .clk     (clk),
    .rst     (rst),
    .step_en (step_en),
    .load_en (load_en),
    .seed_i  (seed_i),
    .state_o (state_o),
    .lockup_o(lockup_o)
);

// File: tb/prbs16_core_tb_top.sv
module prbs16_core_tb_top;
    import prbs16_pkg::*;

    localparam logic [15:0] SAFE = 16'hACE1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic step_en = 1'b0;
    logic load_en = 1'b0;
    logic [15:0] seed = 16'h0000;
    logic [15:0] seed_n;
    assign seed_n = ~seed;

    // index: 0 ext/xor, 1 int/xor, 2 ext/xnor, 3 int/xnor
    logic [15:0] st [4];
    logic        ser [4];
    logic        flg [4];

    always #10 clk = ~clk;

    prbs16_core #(.ARCH(ARCH_EXT), .POL(FB_XOR)) dut_i (
        .clk(clk), .rst(rst), .step_en(step_en), .load_en(load_en), .seed_i(seed),
        .state_o(st[0]), .serial_o(ser[0]), .lockup_o(flg[0]));
    prbs16_core #(.ARCH(ARCH_INT), .POL(FB_XOR)) dut_ix_i (
        .clk(clk), .rst(rst), .step_en(step_en), .load_en(load_en), .seed_i(seed),
        .state_o(st[1]), .serial_o(ser[1]), .lockup_o(flg[1]));
    prbs16_core #(.ARCH(ARCH_EXT), .POL(FB_XNOR)) dut_en_i (
        .clk(clk), .rst(rst), .step_en(step_en), .load_en(load_en), .seed_i(seed_n),
        .state_o(st[2]), .serial_o(ser[2]), .lockup_o(flg[2]));
    prbs16_core #(.ARCH(ARCH_INT), .POL(FB_XNOR)) dut_in_i (
        .clk(clk), .rst(rst), .step_en(step_en), .load_en(load_en), .seed_i(seed_n),
        .state_o(st[3]), .serial_o(ser[3]), .lockup_o(flg[3]));

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;
    logic cmp_on = 1'b0;

    task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // behavioural reference: tap positions counted from the left, 1..16
    function automatic logic [15:0] ext_ref(logic [15:0] s);
        int taps[4] = '{16, 14, 13, 11};
        logic fb = 1'b0;
        foreach (taps[k]) fb = fb ^ s[16 - taps[k]];
        return {fb, s[15:1]};
    endfunction

    function automatic logic [15:0] int_ref(logic [15:0] s);
        int taps[4] = '{16, 14, 13, 11};
        logic [15:0] r = s >> 1;
        if (s[0]) foreach (taps[k]) r[taps[k] - 1] = ~r[taps[k] - 1];
        return r;
    endfunction

    function automatic logic [15:0] ref_next(int v, logic [15:0] s);
        case (v)
            0: return ext_ref(s);
            1: return int_ref(s);
            2: return ~ext_ref(~s);
            default: return ~int_ref(~s);
        endcase
    endfunction

    logic [15:0] m_st [4];
    logic        m_fl [4];

    always @(posedge clk) begin
        for (int v = 0; v < 4; v++) begin
            logic [15:0] sd;
            logic [15:0] bad;
            sd  = (v >= 2) ? seed_n : seed;
            bad = (v >= 2) ? 16'hFFFF : 16'h0000;
            if (rst) begin
                m_st[v] = (v >= 2) ? 16'h0000 : SAFE;
                m_fl[v] = 1'b0;
            end else begin
                m_fl[v] = 1'b0;
                if (load_en) begin
                    if (sd == bad) begin
                        m_st[v] = SAFE;
                        m_fl[v] = 1'b1;
                    end else begin
                        m_st[v] = sd;
                    end
                end else if (step_en) begin
                    m_st[v] = ref_next(v, m_st[v]);
                end
            end
        end
    end

    always @(negedge clk) begin
        if (cmp_on) begin
            for (int v = 0; v < 4; v++) begin
                check(st[v] == m_st[v], $sformatf("R2 R3 R4 R6 variant %0d state", v), st[v], m_st[v]);
                check(ser[v] == m_st[v][0], $sformatf("R5 variant %0d serial", v), ser[v], m_st[v][0]);
                check(flg[v] == m_fl[v], $sformatf("R7 variant %0d flag", v), flg[v], m_fl[v]);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            finish_run();
        end
    end

    initial begin
        logic [15:0] snap [4];
        int          ret [4];
        logic [63:0] pat;
        logic [63:0] win;
        bit          found;

        repeat (3) @(negedge clk);
        // R1: reset values
        for (int v = 0; v < 4; v++) begin
            check(st[v] == ((v >= 2) ? 16'h0000 : SAFE), $sformatf("R1 variant %0d reset state", v), st[v], (v >= 2) ? 16'h0000 : SAFE);
            check(flg[v] == 1'b0, $sformatf("R1 variant %0d reset flag", v), flg[v], 0);
        end
        rst = 1'b0;
        cmp_on = 1'b1;

        // R2: idle cycles hold state
        repeat (4) @(negedge clk);
        for (int v = 0; v < 4; v++)
            check(st[v] == ((v >= 2) ? 16'h0000 : SAFE), $sformatf("R2 variant %0d held", v), st[v], (v >= 2) ? 16'h0000 : SAFE);

        // R3 R4: free running, compared each cycle
        step_en = 1'b1;
        repeat (40) @(negedge clk);

        // R6: load while stepping
        seed = 16'h1234; load_en = 1'b1;
        @(negedge clk);
        load_en = 1'b0;
        check(st[0] == 16'h1234, "R6 load over step ext", st[0], 16'h1234);
        check(st[3] == 16'hEDCB, "R6 load over step int xnor", st[3], 16'hEDCB);
        repeat (20) @(negedge clk);

        // R7: locking seed for every polarity while stepping
        seed = 16'h0000; load_en = 1'b1;
        @(negedge clk);
        load_en = 1'b0;
        for (int v = 0; v < 4; v++) begin
            check(st[v] == SAFE, $sformatf("R7 variant %0d replaced seed", v), st[v], SAFE);
            check(flg[v] == 1'b1, $sformatf("R7 variant %0d flag raised", v), flg[v], 1);
        end
        @(negedge clk);
        for (int v = 0; v < 4; v++)
            check(flg[v] == 1'b0, $sformatf("R7 variant %0d flag one cycle", v), flg[v], 0);

        // R6 R7: opposite polarity pattern is legal
        seed = 16'hFFFF; load_en = 1'b1; step_en = 1'b0;
        @(negedge clk);
        load_en = 1'b0;
        check(st[1] == 16'hFFFF && flg[1] == 1'b0, "R6 all-ones legal for xor", st[1], 16'hFFFF);
        check(st[2] == 16'h0000 && flg[2] == 1'b0, "R6 all-zeros legal for xnor", st[2], 16'h0000);

        // R8 R9 R10: full period
        seed = 16'h0001; load_en = 1'b1;
        @(negedge clk);
        load_en = 1'b0; step_en = 1'b1;
        for (int v = 0; v < 4; v++) begin snap[v] = st[v]; ret[v] = 0; end
        pat = '0; win = '0; found = 1'b0;
        pat = {pat[62:0], ser[1]};
        win = {win[62:0], ser[0]};
        for (int c = 1; c <= 65535 + 64; c++) begin
            @(negedge clk);
            for (int v = 0; v < 4; v++)
                if (ret[v] == 0 && st[v] == snap[v]) ret[v] = c;
            if (c < 64) pat = {pat[62:0], ser[1]};
            win = {win[62:0], ser[0]};
            if (c >= 63 && win == pat) found = 1'b1;
            check(st[2] == ~st[0], "R10 ext xnor complement", st[2], ~st[0]);
            check(st[3] == ~st[1], "R10 int xnor complement", st[3], ~st[1]);
        end
        for (int v = 0; v < 4; v++)
            check(ret[v] == 65535, $sformatf("R8 variant %0d period", v), ret[v], 65535);
        check(found, "R9 streams align", found, 1);

        step_en = 1'b0;
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule